// File: doc/BRIEF.md
# Scratchpad Memory Command Controller

This block is the command layer of a small single-wire memory device. It sits above a bit/byte engine that delivers received bytes, asks for bytes to transmit and signals a line reset. It holds 32 bytes of data memory with a 32-byte staging scratchpad, an 8-byte one-time-programmable application register with its own 8-byte staging buffer, and a lock flag that is reported through a status byte.

Every transaction starts after a line reset with a command byte. Depending on the command, the block then expects a start address, a stream of data bytes, or a validation key. Address counters advance after every byte and wrap at the end of the addressed area. Copy operations commit staged data at once and then hold a busy flag for a programmable number of clock cycles. While the flag is set, the block accepts no bytes. Non-volatile storage is modelled as flip-flops.

Top module: `spad_mem_ctrl`

## Requirements
- R1: After rst_n is released, busy and tx_valid are low, every storage byte is 00h, the lock is clear and the status byte reads FFh.
- R2: Command 0Fh takes a start address (only its low 5 bits are used) and then data bytes, which are written into the data scratchpad. The address increments after each byte and wraps from 1Fh to 00h.
- R3: Command AAh takes a start address (low 5 bits) and then answers each tx_req with the scratchpad byte at the current address, incrementing with the same wrap. The byte appears on tx_byte, with tx_valid high, in the cycle after tx_req.
- R4: Command 55h followed by key A5h copies the whole data scratchpad into data memory. busy then rises in the next cycle and stays high for exactly PROG_CYCLES cycles.
- R5: Command F0h copies all of data memory into the scratchpad as soon as the command byte arrives, even if a line reset follows at once. It then streams from the given start address with the 1Fh wrap.
- R6: Command 99h takes a start address (low 3 bits) and writes data into the register staging buffer, wrapping from 07h to 00h. Once locked, these bytes are discarded.
- R7: Command C3h takes a start address (low 3 bits) and streams with the 07h wrap. It reads the staging buffer while unlocked and the application register once locked.
- R8: Command 5Ah followed by key A5h copies the staging buffer into the application register, sets the lock and starts the busy interval. When already locked it changes nothing and starts no busy interval.
- R9: Command 66h followed by key 00h answers every later tx_req with the status byte: FFh unlocked, FCh locked.
- R10: An unknown command or a wrong key leaves all storage unchanged and starts no busy interval. The block ignores every byte after it until the next line reset.
- R11: While busy is high, received bytes, line resets included, cause no storage change, and tx_req is answered with FFh.
- R12: A tx_req outside a read stream or status stream is answered with FFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rst | input | 1 | Line reset strobe; returns the sequencer to command state |
| rx_valid | input | 1 | Strobe: rx_byte holds a received byte |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Strobe: the byte layer needs a byte to send |
| tx_valid | output | 1 | Pulses one cycle after tx_req |
| tx_byte | output | 8 | Byte to transmit, valid with tx_valid |
| busy | output | 1 | Programming interval in progress |

## Verification
If an address counter is wrong, a wrong byte shows up in the first read after a wrap, so the bench runs streams long enough to cross 1Fh and 07h. A lost or misplaced copy does not show at once. It appears only when the target is read in a later transaction, so every copy is followed by a full readback through the normal commands. A stuck or early lock shows in the very next status byte and in the source of C3h reads. A wrong busy length shows at the busy pin in the cycle the count expires.

// File: rtl/spad_pkg.sv
package spad_pkg;
    // Sequencer phases within one transaction
    typedef enum logic [2:0] {
        ST_CMD, ST_ADDR, ST_WDATA, ST_RDATA, ST_KEY, ST_STAT, ST_HOLD
    } seq_st_e;

    // Decoded operation of the current transaction
    typedef enum logic [2:0] {
        OP_NONE, OP_WSP, OP_RSP, OP_WAPP, OP_RAPP, OP_CPY, OP_LOCK, OP_STAT
    } op_e;

    localparam logic [7:0] CMD_WSP   = 8'h0F;
    localparam logic [7:0] CMD_RSP   = 8'hAA;
    localparam logic [7:0] CMD_CPY   = 8'h55;
    localparam logic [7:0] CMD_RMEM  = 8'hF0;
    localparam logic [7:0] CMD_WAPP  = 8'h99;
    localparam logic [7:0] CMD_STAT  = 8'h66;
    localparam logic [7:0] CMD_RAPP  = 8'hC3;
    localparam logic [7:0] CMD_LOCK  = 8'h5A;
    localparam logic [7:0] KEY_COPY  = 8'hA5;
    localparam logic [7:0] KEY_STAT  = 8'h00;
    localparam logic [7:0] STS_OPEN  = 8'hFF;
    localparam logic [7:0] STS_SHUT  = 8'hFC;
    localparam logic [7:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/spad_prog_timer.sv
// Programming interval counter.
// Loads PROG_CYCLES on start and counts down; busy is high while non-zero.
// Assumes start is never raised while busy (the sequencer blocks it).
module spad_prog_timer #(
    parameter int PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] cnt;

    // Load on start, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= CW'(PROG_CYCLES);
        else if (cnt != '0)  cnt <= cnt - CW'(1);
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/spad_store.sv
// Storage array: data scratchpad, data memory, register staging buffer,
// application register and lock flag, all as flip-flops.
// Assumes byte counts are powers of two and strobes are mutually exclusive.
module spad_store #(
    parameter int MEM_BYTES = 32,
    parameter int APP_BYTES = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(MEM_BYTES)-1:0] addr,
    input  logic [7:0]                   wr_data,
    input  logic                         wr_sp,
    input  logic                         wr_rsp,
    input  logic                         load_sp,
    input  logic                         copy_sp,
    input  logic                         copy_lock,
    input  logic                         rd_app,
    output logic [7:0]                   rd_data,
    output logic                         locked
);
    localparam int AAW = $clog2(APP_BYTES);

    logic [MEM_BYTES-1:0][7:0] sp;
    logic [MEM_BYTES-1:0][7:0] mem;
    logic [APP_BYTES-1:0][7:0] rsp;
    logic [APP_BYTES-1:0][7:0] app;
    logic                      lock_q;

    // Data scratchpad: bulk load from memory or single-byte write
    always_ff @(posedge clk) begin
        if (!rst_n)       sp <= '0;
        else if (load_sp) sp <= mem;
        else if (wr_sp)   sp[addr] <= wr_data;
    end

    // Data memory: whole-page commit from the scratchpad
    always_ff @(posedge clk) begin
        if (!rst_n)       mem <= '0;
        else if (copy_sp) mem <= sp;
    end

    // Register staging buffer: single-byte write
    always_ff @(posedge clk) begin
        if (!rst_n)      rsp <= '0;
        else if (wr_rsp) rsp[addr[AAW-1:0]] <= wr_data;
    end

    // Application register and lock: one commit sets both
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            app    <= '0;
            lock_q <= 1'b0;
        end else if (copy_lock) begin
            app    <= rsp;
            lock_q <= 1'b1;
        end
    end

    // Read source depends on area and lock state
    always_comb begin
        if (rd_app) rd_data = lock_q ? app[addr[AAW-1:0]] : rsp[addr[AAW-1:0]];
        else        rd_data = sp[addr];
    end

    assign locked = lock_q;

    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);
    a_r8_app_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> $stable(app));
    a_r6_rsp_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> $stable(rsp));
endmodule

// File: rtl/spad_cmd_seq.sv
// Command sequencer: decodes command, address and key bytes, keeps the
// wrapping address counter and drives storage strobes and the tx byte.
// Assumes bus_rst, rx_valid and tx_req are single-cycle strobes.
module spad_cmd_seq
    import spad_pkg::*;
#(
    parameter int MEM_BYTES = 32,
    parameter int APP_BYTES = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_rst,
    input  logic                         rx_valid,
    input  logic [7:0]                   rx_byte,
    input  logic                         tx_req,
    input  logic                         busy,
    input  logic                         locked,
    input  logic [7:0]                   rd_data,
    output logic [$clog2(MEM_BYTES)-1:0] addr,
    output logic                         rd_app,
    output logic                         wr_sp,
    output logic                         wr_rsp,
    output logic                         load_sp,
    output logic                         copy_sp,
    output logic                         copy_lock,
    output logic                         prog_start,
    output logic                         tx_valid,
    output logic [7:0]                   tx_byte
);
    localparam int             MAW      = $clog2(MEM_BYTES);
    localparam logic [MAW-1:0] MEM_MASK = MAW'(MEM_BYTES - 1);
    localparam logic [MAW-1:0] APP_MASK = MAW'(APP_BYTES - 1);

    seq_st_e        st;
    op_e            op;
    logic           byte_ok;
    logic           key_ok;
    logic [MAW-1:0] addr_mask;
    logic [MAW-1:0] addr_inc;

    assign byte_ok   = rx_valid && !busy && !bus_rst;
    assign key_ok    = byte_ok && (st == ST_KEY) && (rx_byte == KEY_COPY);
    assign rd_app    = (op == OP_RAPP);
    assign addr_mask = (op == OP_WAPP || op == OP_RAPP) ? APP_MASK : MEM_MASK;
    assign addr_inc  = (addr + MAW'(1)) & addr_mask;

    assign wr_sp      = byte_ok && (st == ST_WDATA) && (op == OP_WSP);
    assign wr_rsp     = byte_ok && (st == ST_WDATA) && (op == OP_WAPP) && !locked;
    assign load_sp    = byte_ok && (st == ST_CMD) && (rx_byte == CMD_RMEM);
    assign copy_sp    = key_ok && (op == OP_CPY);
    assign copy_lock  = key_ok && (op == OP_LOCK) && !locked;
    assign prog_start = copy_sp || copy_lock;

    // Transaction phase, operation and address counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_CMD;
            op   <= OP_NONE;
            addr <= '0;
        end else if (bus_rst && !busy) begin
            st <= ST_CMD;
            op <= OP_NONE;
        end else begin
            if (byte_ok) begin
                case (st)
                    ST_CMD: begin
                        st <= ST_ADDR;
                        case (rx_byte)
                            CMD_WSP:  op <= OP_WSP;
                            CMD_RSP:  op <= OP_RSP;
                            CMD_RMEM: op <= OP_RSP;
                            CMD_WAPP: op <= OP_WAPP;
                            CMD_RAPP: op <= OP_RAPP;
                            CMD_CPY:  begin op <= OP_CPY;  st <= ST_KEY; end
                            CMD_LOCK: begin op <= OP_LOCK; st <= ST_KEY; end
                            CMD_STAT: begin op <= OP_STAT; st <= ST_KEY; end
                            default:  begin op <= OP_NONE; st <= ST_HOLD; end
                        endcase
                    end
                    ST_ADDR: begin
                        addr <= rx_byte[MAW-1:0] & addr_mask;
                        st   <= (op == OP_WSP || op == OP_WAPP) ? ST_WDATA : ST_RDATA;
                    end
                    ST_WDATA: addr <= addr_inc;
                    ST_KEY: st <= (op == OP_STAT && rx_byte == KEY_STAT) ? ST_STAT : ST_HOLD;
                    default: ;
                endcase
            end
            if (tx_req && !busy && st == ST_RDATA) addr <= addr_inc;
        end
    end

    // Answer every tx_req one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= IDLE_BYTE;
        end else begin
            tx_valid <= tx_req;
            if (tx_req) begin
                if (busy)                tx_byte <= IDLE_BYTE;
                else if (st == ST_RDATA) tx_byte <= rd_data;
                else if (st == ST_STAT)  tx_byte <= locked ? STS_SHUT : STS_OPEN;
                else                     tx_byte <= IDLE_BYTE;
            end
        end
    end

    a_r10_hold_blocks_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |-> !prog_start && !wr_sp && !wr_rsp);
endmodule

// File: rtl/spad_mem_ctrl.sv
// Top of the scratchpad memory command controller: sequencer, storage and
// programming timer. Assumes the byte layer below delivers single-cycle
// strobes and serialises bytes least significant bit first itself.
module spad_mem_ctrl #(
    parameter int MEM_BYTES   = 32,
    parameter int APP_BYTES   = 8,
    parameter int PROG_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       tx_req,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    output logic       busy
);
    localparam int MAW = $clog2(MEM_BYTES);

    logic [MAW-1:0] addr;
    logic           rd_app, wr_sp, wr_rsp, load_sp, copy_sp, copy_lock;
    logic           prog_start, locked;
    logic [7:0]     rd_data;

    spad_cmd_seq #(.MEM_BYTES(MEM_BYTES), .APP_BYTES(APP_BYTES)) u_seq (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_req(tx_req), .busy(busy), .locked(locked),
        .rd_data(rd_data), .addr(addr), .rd_app(rd_app), .wr_sp(wr_sp),
        .wr_rsp(wr_rsp), .load_sp(load_sp), .copy_sp(copy_sp),
        .copy_lock(copy_lock), .prog_start(prog_start),
        .tx_valid(tx_valid), .tx_byte(tx_byte)
    );

    spad_store #(.MEM_BYTES(MEM_BYTES), .APP_BYTES(APP_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(rx_byte),
        .wr_sp(wr_sp), .wr_rsp(wr_rsp), .load_sp(load_sp), .copy_sp(copy_sp),
        .copy_lock(copy_lock), .rd_app(rd_app), .rd_data(rd_data),
        .locked(locked)
    );

    spad_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy)
    );

    a_r4_busy_follows_copy: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> busy);
    a_r11_sp_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(u_store.sp));
    a_r11_mem_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(u_store.mem));
endmodule

// File: tb/tb_spad_mem_ctrl.sv
module tb_spad_mem_ctrl;
    localparam int PROG = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rst = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_req = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       busy;

    int checks = 0;
    int bad = 0;

    logic [7:0] m_sp  [32];
    logic [7:0] m_mem [32];
    logic [7:0] m_rsp [8];
    logic [7:0] m_app [8];
    logic       m_lock = 1'b0;

    always #5 clk = ~clk;

    spad_mem_ctrl #(.PROG_CYCLES(PROG)) dut (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_req(tx_req), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .busy(busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic line_rst();
        bus_rst = 1'b1;
        @(negedge clk);
        bus_rst = 1'b0;
    endtask

    task automatic get(output logic [7:0] b);
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
        b = tx_byte;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
    endtask

    function automatic logic [7:0] status_exp();
        return m_lock ? 8'hFC : 8'hFF;
    endfunction

    // Write cnt random bytes to the data scratchpad (R2)
    task automatic w_sp(input logic [7:0] start, input int cnt);
        int a = start & 31;
        line_rst(); put(8'h0F); put(start);
        for (int i = 0; i < cnt; i++) begin
            logic [7:0] d = 8'($urandom);
            put(d); m_sp[a] = d; a = (a + 1) & 31;
        end
    endtask

    // Stream the scratchpad with command cmd and compare (R3, R5)
    task automatic r_sp(input logic [7:0] cmd, input logic [7:0] start,
                        input int cnt, input string tag);
        int a = start & 31;
        logic [7:0] b;
        line_rst(); put(cmd); put(start);
        for (int i = 0; i < cnt; i++) begin
            get(b); chk(tag, b, m_sp[a]); a = (a + 1) & 31;
        end
    endtask

    task automatic w_app(input logic [7:0] start, input int cnt);
        int a = start & 7;
        line_rst(); put(8'h99); put(start);
        for (int i = 0; i < cnt; i++) begin
            logic [7:0] d = 8'($urandom);
            put(d);
            if (!m_lock) m_rsp[a] = d;
            a = (a + 1) & 7;
        end
    endtask

    task automatic r_app(input logic [7:0] start, input int cnt, input string tag);
        int a = start & 7;
        logic [7:0] b;
        line_rst(); put(8'hC3); put(start);
        for (int i = 0; i < cnt; i++) begin
            get(b); chk(tag, b, m_lock ? m_app[a] : m_rsp[a]); a = (a + 1) & 7;
        end
    endtask

    task automatic r_stat(input string tag);
        logic [7:0] b;
        line_rst(); put(8'h66); put(8'h00);
        get(b); chk(tag, b, status_exp());
        get(b); chk(tag, b, status_exp());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        logic [7:0] b;
        int n;
        void'($urandom(32'd2024));
        for (int i = 0; i < 32; i++) begin m_sp[i] = 8'h00; m_mem[i] = 8'h00; end
        for (int i = 0; i < 8; i++) begin m_rsp[i] = 8'h00; m_app[i] = 8'h00; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 busy", busy, 0);
        chk("R1 tx_valid", tx_valid, 0);
        r_stat("R1 status");
        r_sp(8'hAA, 8'h00, 4, "R1 scratchpad zero");

        // R12: tx_req in command state gives FFh with tx_valid
        line_rst(); get(b);
        chk("R12 idle byte", b, 8'hFF);
        chk("R3 tx_valid", tx_valid, 1);

        // R2/R3: random writes across the wrap, upper address bits ignored
        for (int k = 0; k < 4; k++) begin
            w_sp(8'($urandom), 20 + int'($urandom % 20));
            r_sp(8'hAA, 8'($urandom), 35, "R3 read scratchpad");
        end
        w_sp(8'hFE, 3);
        r_sp(8'hAA, 8'h1E, 4, "R2 wrap 1Fh->00h");

        // R10: wrong copy key, then trailing bytes ignored
        line_rst(); put(8'h55); put(8'hA4); put(8'h0F); put(8'h00); put(8'h77);
        chk("R10 wrong key no busy", busy, 0);
        r_sp(8'hAA, 8'h00, 32, "R10 scratchpad unchanged");
        // R10: unknown command
        line_rst(); put(8'h12); put(8'h0F); put(8'h01); put(8'h33);
        r_sp(8'hAA, 8'h00, 32, "R10 unknown cmd");

        // R4: copy with the right key and busy length
        line_rst(); put(8'h55); put(8'hA5);
        for (int i = 0; i < 32; i++) m_mem[i] = m_sp[i];
        busy_len(n);
        chk("R4 busy length", n, PROG);

        // R5: overwrite scratchpad, then read memory with immediate reset
        w_sp(8'h00, 32);
        line_rst(); put(8'hF0); line_rst();
        for (int i = 0; i < 32; i++) m_sp[i] = m_mem[i];
        r_sp(8'hAA, 8'h00, 32, "R5 reset after F0 still copies");
        w_sp(8'h05, 10);
        for (int i = 0; i < 32; i++) m_sp[i] = m_mem[i];
        r_sp(8'hF0, 8'h1C, 36, "R5 read memory stream");

        // R6/R7: register staging writes with 07h wrap, read while unlocked
        w_app(8'hF6, 11);
        r_app(8'h03, 9, "R7 read staging unlocked");
        w_app(8'h07, 2);
        r_app(8'h07, 2, "R6 wrap 07h->00h");
        r_stat("R9 status open");

        // R10: wrong lock key
        line_rst(); put(8'h5A); put(8'h00);
        chk("R10 lock wrong key busy", busy, 0);
        r_stat("R10 lock wrong key status");

        // R8: lock, and R11 ignore during busy
        line_rst(); put(8'h5A); put(8'hA5);
        m_lock = 1'b1;
        for (int i = 0; i < 8; i++) m_app[i] = m_rsp[i];
        chk("R8 busy after lock", busy, 1);
        line_rst(); put(8'h0F); put(8'h00); put(8'hEE);
        get(b);
        chk("R11 tx during busy", b, 8'hFF);
        busy_len(n);
        chk("R11 busy remains", n > 0 ? 1 : 0, 1);
        r_sp(8'hAA, 8'h00, 32, "R11 scratchpad unchanged");
        r_stat("R9 status locked");
        r_app(8'h00, 10, "R7 read locked register");

        // R6: writes discarded once locked; R8: second lock does nothing
        w_app(8'h00, 8);
        r_app(8'h02, 8, "R6 locked write discarded");
        line_rst(); put(8'h5A); put(8'hA5);
        chk("R8 relock no busy", busy, 0);
        r_app(8'h00, 8, "R8 relock no change");

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule